// File: doc/BRIEF.md
# Sub-page write permission walker

This block decides whether a guest write may proceed when memory is protected at a granularity finer than a 4 KB page. Each request carries a guest physical address, an access-type flag, a global enable, and two bits taken from the leaf translation entry: the sub-page-protect flag and the page-writable flag. Reads, disabled checking and pages that are already writable are settled at once, with no table access. Every other write walks a four-level table through a single 64-bit read port. The walk starts at a root pointer and ends in a bitmap in which even bits grant write permission for each 128-byte slice of the page.

The result reports one of four outcomes: allow, page-level permission violation, table miss, or table misconfiguration. A 64-bit qualification word tells a miss from a misconfiguration, and the request address is echoed with the result. Requests use a valid/ready handshake. The table port keeps at most one read in flight and waits for a data-valid return.

Top module: `subpage_wr_guard`

## Requirements
- R1: A request with `req_write`=0 produces result code 0 (allow) in the cycle after acceptance, with no table read.
- R2: A write with `req_enable`=0 or `req_leaf_sub`=0 issues no table read. The result is 0 (allow) when `req_leaf_wr`=1 and 1 (violation) otherwise.
- R3: A write with `req_enable`=1, `req_leaf_sub`=1 and `req_leaf_wr`=1 produces code 0 with no table read.
- R4: Otherwise the block reads four entries in turn. The first read is at the root pointer with its low 12 bits cleared, plus 8 × address bits 47:39. Each later read is at the previous entry's bits PA_W-1:12 shifted left by 12, plus 8 × the next index (bits 38:30, then 29:21, then 20:12). Every read address is 8-byte aligned.
- R5: In the last entry, bit 2·k is selected, where k is address bits 11:7. A 1 gives code 0 (allow) and a 0 gives code 1 (violation).
- R6: A directory entry (one of the first three) with any of bits 11:1 or bits 63:PA_W set, or a last entry with any odd bit set, ends the walk with code 3 (misconfiguration). This holds even when the entry's bit 0 is clear.
- R7: A directory entry that is well formed but has bit 0 (present) clear ends the walk with code 2 (miss). No further read is made.
- R8: `res_qual` is 64'h800 (bit 11 set) for code 2 and zero for every other code. `res_gpa` equals the request address.
- R9: Exactly one `res_valid` pulse follows each accepted request. `req_ready` stays low from acceptance through the result cycle.
- R10: `mem_req` is a one-cycle pulse, and a new read is not issued before `mem_rvalid` has returned the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_gpa | input | 64 | Guest physical address of the access |
| req_write | input | 1 | 1 for a write access |
| req_enable | input | 1 | Global sub-page checking enable |
| req_leaf_sub | input | 1 | Sub-page-protect flag from the leaf translation entry |
| req_leaf_wr | input | 1 | Writable flag from the leaf translation entry |
| root_ptr | input | 64 | Physical address of the top table; low 12 bits ignored |
| mem_req | output | 1 | Table read request pulse |
| mem_addr | output | 64 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry returned by the table port |
| res_valid | output | 1 | Result pulse |
| res_code | output | 2 | 0 allow, 1 violation, 2 miss, 3 misconfiguration |
| res_qual | output | 64 | Qualification word |
| res_gpa | output | 64 | Address of the checked request |

## Verification
If the level counter or the table base register holds a wrong value, the block reads from an address the bench has not filled. The zero entry returned comes back as a miss on the very request that caused it, and the read count differs from the expected one. A misordered check in the entry logic shows up on the next malformed entry as a miss where a misconfiguration is expected. A stuck state machine shows up as a missing or extra result pulse, or as `req_ready` rising early, and this appears within a few cycles of the faulty step.

// File: rtl/spw_pkg.sv
package spw_pkg;

    localparam int GPA_W    = 64;
    localparam int ENT_W    = 64;
    localparam int IDX_W    = 9;
    localparam int LEVELS   = 4;
    localparam int LVL_W    = $clog2(LEVELS);
    localparam int PG_SH    = 12;
    localparam int SLICES   = ENT_W / 2;
    localparam int SLICE_W  = $clog2(SLICES);
    localparam int SLICE_SH = 7;

    localparam logic [ENT_W-1:0] QUAL_MISS = 64'h0000_0000_0000_0800;

    typedef enum logic [1:0] {
        RES_ALLOW  = 2'd0,
        RES_VIOL   = 2'd1,
        RES_MISS   = 2'd2,
        RES_MISCFG = 2'd3
    } spw_res_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } spw_state_e;

    // Outcome of the fast decision taken at request acceptance.
    typedef struct packed {
        logic     walk;
        spw_res_e code;
    } spw_fast_t;

    function automatic spw_fast_t fast_decide(input logic wr, input logic en,
                                              input logic sub, input logic leaf_wr);
        spw_fast_t f;
        f.walk = 1'b0;
        f.code = RES_ALLOW;
        if (wr) begin
            if (!(en && sub)) begin
                f.code = leaf_wr ? RES_ALLOW : RES_VIOL;
            end else if (!leaf_wr) begin
                f.walk = 1'b1;
            end
        end
        return f;
    endfunction

endpackage

// File: rtl/spw_dir_check.sv
module spw_dir_check
    import spw_pkg::*;
#(
    parameter int PA_W = 46
) (
    input  logic [ENT_W-1:0] entry,
    output logic             bad,
    output logic             present,
    output logic [ENT_W-1:0] next_base
);
    localparam int HI_W = ENT_W - PA_W;

    logic low_resv;
    logic high_resv;

    always_comb begin
        low_resv  = |entry[PG_SH-1:1];
        high_resv = |entry[ENT_W-1:PA_W];
        bad       = low_resv || high_resv;
        present   = entry[0];
        next_base = {{HI_W{1'b0}}, entry[PA_W-1:PG_SH], {PG_SH{1'b0}}};
    end
endmodule

// File: rtl/spw_leaf_check.sv
module spw_leaf_check
    import spw_pkg::*;
(
    input  logic [ENT_W-1:0]   entry,
    input  logic [SLICE_W-1:0] slice,
    output logic               bad,
    output logic               granted
);
    logic [SLICES-1:0] even_bits;
    logic [SLICES-1:0] odd_bits;

    for (genvar i = 0; i < SLICES; i++) begin : g_split
        assign even_bits[i] = entry[2*i];
        assign odd_bits[i]  = entry[2*i+1];
    end

    assign bad     = |odd_bits;
    assign granted = even_bits[slice];
endmodule

// File: rtl/spw_addr_gen.sv
module spw_addr_gen
    import spw_pkg::*;
(
    input  logic [ENT_W-1:0]                 base,
    input  logic [IDX_W*LEVELS+PG_SH-1:PG_SH] gpa_idx,
    input  logic [LVL_W-1:0]                 lvl,
    output logic [ENT_W-1:0]                 addr
);
    logic [IDX_W-1:0] idx_of [LEVELS];

    for (genvar l = 0; l < LEVELS; l++) begin : g_idx
        assign idx_of[l] = gpa_idx[PG_SH + IDX_W*l +: IDX_W];
    end

    assign addr = base + (ENT_W'(idx_of[lvl]) << 3);
endmodule

// File: rtl/subpage_wr_guard.sv
module subpage_wr_guard
    import spw_pkg::*;
#(
    parameter int PA_W = 46
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [GPA_W-1:0] req_gpa,
    input  logic             req_write,
    input  logic             req_enable,
    input  logic             req_leaf_sub,
    input  logic             req_leaf_wr,
    input  logic [ENT_W-1:0] root_ptr,
    output logic             mem_req,
    output logic [ENT_W-1:0] mem_addr,
    input  logic             mem_rvalid,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic             res_valid,
    output logic [1:0]       res_code,
    output logic [ENT_W-1:0] res_qual,
    output logic [GPA_W-1:0] res_gpa
);
    localparam int IDX_TOP = IDX_W*LEVELS + PG_SH;

    spw_state_e       state_q;
    logic [LVL_W-1:0] lvl_q;
    logic [ENT_W-1:0] base_q;
    logic [GPA_W-1:0] gpa_q;
    spw_res_e         code_q;
    logic [ENT_W-1:0] qual_q;

    logic             accept;
    spw_fast_t        fast;
    logic             dir_bad;
    logic             dir_present;
    logic [ENT_W-1:0] dir_next;
    logic             leaf_bad;
    logic             leaf_granted;

    spw_dir_check #(.PA_W(PA_W)) u_dir (
        .entry     (mem_rdata),
        .bad       (dir_bad),
        .present   (dir_present),
        .next_base (dir_next)
    );

    spw_leaf_check u_leaf (
        .entry   (mem_rdata),
        .slice   (gpa_q[SLICE_SH +: SLICE_W]),
        .bad     (leaf_bad),
        .granted (leaf_granted)
    );

    spw_addr_gen u_addr (
        .base    (base_q),
        .gpa_idx (gpa_q[IDX_TOP-1:PG_SH]),
        .lvl     (lvl_q),
        .addr    (mem_addr)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign fast      = fast_decide(req_write, req_enable, req_leaf_sub, req_leaf_wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
            base_q  <= '0;
            gpa_q   <= '0;
            code_q  <= RES_ALLOW;
            qual_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        gpa_q  <= req_gpa;
                        lvl_q  <= LVL_W'(LEVELS - 1);
                        base_q <= {root_ptr[ENT_W-1:PG_SH], {PG_SH{1'b0}}};
                        qual_q <= '0;
                        code_q <= fast.code;
                        state_q <= fast.walk ? ST_ISSUE : ST_DONE;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        if (lvl_q != '0) begin
                            if (dir_bad) begin
                                code_q  <= RES_MISCFG;
                                state_q <= ST_DONE;
                            end else if (!dir_present) begin
                                code_q  <= RES_MISS;
                                qual_q  <= QUAL_MISS;
                                state_q <= ST_DONE;
                            end else begin
                                base_q  <= dir_next;
                                lvl_q   <= lvl_q - 1'b1;
                                state_q <= ST_ISSUE;
                            end
                        end else begin
                            if (leaf_bad) begin
                                code_q <= RES_MISCFG;
                            end else begin
                                code_q <= leaf_granted ? RES_ALLOW : RES_VIOL;
                            end
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req   = (state_q == ST_ISSUE);
    assign res_valid = (state_q == ST_DONE);
    assign res_code  = code_q;
    assign res_qual  = qual_q;
    assign res_gpa   = gpa_q;

    AST_READ_FAST: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write) |=> (res_valid && res_code == RES_ALLOW)); // R1

    AST_NO_WALK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write && !(req_enable && req_leaf_sub)) |=> !mem_req); // R2

    AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[2:0] == 3'b000)); // R4

    AST_QUAL_MISS_BIT: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_qual[11] == (res_code == RES_MISS))); // R8

    AST_QUAL_OTHER_ZERO: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ((res_qual & ~QUAL_MISS) == '0)); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (mem_req || res_valid) |-> !req_ready); // R9

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R9

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R10
endmodule

// File: tb/subpage_wr_guard_tb_top.sv
`timescale 1ns/1ps
module subpage_wr_guard_tb_top;
    import spw_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_gpa = '0;
    logic        req_write = 1'b0;
    logic        req_enable = 1'b0;
    logic        req_leaf_sub = 1'b0;
    logic        req_leaf_wr = 1'b0;
    logic [63:0] root_ptr;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        res_valid;
    logic [1:0]  res_code;
    logic [63:0] res_qual;
    logic [63:0] res_gpa;

    localparam logic [63:0] ROOT = 64'h0000_0000_1000_0ABC;
    localparam logic [63:0] TB3  = 64'h0000_0000_2000_0000;
    localparam logic [63:0] TB2  = 64'h0000_0000_2000_1000;
    localparam logic [63:0] TB1  = 64'h0000_0000_2000_2000;
    localparam logic [63:0] G1   = 64'h0000_1234_5678_9F80;
    localparam logic [63:0] G2   = 64'h0000_7654_3210_A000;
    localparam logic [63:0] EVEN = 64'h5555_5555_5555_5555;

    assign root_ptr = ROOT;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [1:0]  code;
        logic [63:0] qual;
        logic [63:0] gpa;
        int          nreads;
        string       tag;
    } exp_t;

    exp_t sb[$];

    logic [63:0] tbl [logic [63:0]];
    logic [63:0] a4, a3, a2, a1;
    int  rd_cnt = 0;
    bit  outstanding = 0;
    bit  overlap = 0;

    always #4 clk = ~clk;

    subpage_wr_guard dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_gpa(req_gpa),
        .req_write(req_write), .req_enable(req_enable),
        .req_leaf_sub(req_leaf_sub), .req_leaf_wr(req_leaf_wr),
        .root_ptr(root_ptr),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .res_valid(res_valid), .res_code(res_code),
        .res_qual(res_qual), .res_gpa(res_gpa)
    );

    // Table memory model: one cycle read latency, absent entries read as zero.
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= tbl.exists(mem_addr) ? tbl[mem_addr] : 64'h0;
        end
    end

    task automatic check(input bit ok, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Monitor: pops expected items as results appear.
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req) begin
                if (outstanding) overlap = 1;
                outstanding = 1;
                rd_cnt++;
            end
            if (mem_rvalid) outstanding = 0;
            if (res_valid) begin
                if (sb.size() == 0) begin
                    check(0, "R9 result without request", 64'(res_code), 64'hx);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(res_code == e.code, {e.tag, " code"}, 64'(res_code), 64'(e.code));
                    check(res_qual == e.qual && res_gpa == e.gpa, "R8 qual/gpa",
                          res_qual ^ res_gpa, e.qual ^ e.gpa);
                    check(rd_cnt == e.nreads, {e.tag, " read count"}, 64'(rd_cnt),
                          64'(e.nreads));
                    check(!req_ready && !overlap, "R9 R10 ready low, single read",
                          {62'd0, req_ready, overlap}, 64'd0);
                end
                rd_cnt  = 0;
                overlap = 0;
            end
        end
    end

    task automatic send(input bit wr, input bit en, input bit sub, input bit lwr,
                        input logic [63:0] gpa, input spw_res_e code, input int nreads,
                        input string tag);
        exp_t e;
        e.code   = code;
        e.qual   = (code == RES_MISS) ? QUAL_MISS : 64'h0;
        e.gpa    = gpa;
        e.nreads = nreads;
        e.tag    = tag;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_enable = en;
        req_leaf_sub = sub; req_leaf_wr = lwr; req_gpa = gpa;
        @(posedge clk);
        #1 req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic map_path(input logic [63:0] gpa, input logic [63:0] leaf);
        tbl.delete();
        a4 = {ROOT[63:12], 12'h0} + (64'(gpa[47:39]) << 3);
        a3 = TB3 + (64'(gpa[38:30]) << 3);
        a2 = TB2 + (64'(gpa[29:21]) << 3);
        a1 = TB1 + (64'(gpa[20:12]) << 3);
        tbl[a4] = TB3 | 64'h1;
        tbl[a3] = TB2 | 64'h1;
        tbl[a2] = TB1 | 64'h1;
        tbl[a1] = leaf;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "reset ready", 64'(req_ready), 64'h1);
        check(res_valid == 1'b0, "reset res_valid", 64'(res_valid), 64'h0);
        check(mem_req == 1'b0, "reset mem_req", 64'(mem_req), 64'h0);

        send(0, 1, 1, 0, G1, RES_ALLOW, 0, "R1 read bypass");
        send(1, 0, 1, 0, G1, RES_VIOL,  0, "R2 disabled, not writable");
        send(1, 0, 1, 1, G1, RES_ALLOW, 0, "R2 disabled, writable");
        send(1, 1, 0, 0, G2, RES_VIOL,  0, "R2 leaf flag clear");
        send(1, 1, 1, 1, G2, RES_ALLOW, 0, "R3 leaf writable");

        map_path(G1, 64'h1 << 62);
        send(1, 1, 1, 0, G1, RES_ALLOW, 4, "R4 R5 slice 31 granted");
        map_path(G1, EVEN & ~(64'h1 << 62));
        send(1, 1, 1, 0, G1, RES_VIOL, 4, "R5 slice 31 denied");
        map_path(G2, 64'h1);
        send(1, 1, 1, 0, G2, RES_ALLOW, 4, "R5 slice 0 granted");
        map_path(G2, 64'h4);
        send(1, 1, 1, 0, G2, RES_VIOL, 4, "R5 slice 0 denied");

        map_path(G1, EVEN);
        tbl[a4] = 64'h0;
        send(1, 1, 1, 0, G1, RES_MISS, 1, "R7 top level absent");
        map_path(G1, EVEN);
        tbl[a2] = TB1;
        send(1, 1, 1, 0, G1, RES_MISS, 3, "R7 third level absent");

        map_path(G1, EVEN);
        tbl[a3] = tbl[a3] | (64'h1 << 5);
        send(1, 1, 1, 0, G1, RES_MISCFG, 2, "R6 low reserved bit");
        map_path(G1, EVEN);
        tbl[a2] = 64'h1 << 50;
        send(1, 1, 1, 0, G1, RES_MISCFG, 3, "R6 beats absence");
        map_path(G1, EVEN);
        tbl[a4] = TB3 | 64'h1 | (64'h1 << 46);
        send(1, 1, 1, 0, G1, RES_MISCFG, 1, "R6 bit at address width");
        map_path(G1, 64'h3);
        send(1, 1, 1, 0, G1, RES_MISCFG, 4, "R6 odd leaf bit");

        repeat (4) @(negedge clk);
        check(res_valid == 1'b0 && sb.size() == 0, "R9 no stray result",
              64'(res_valid), 64'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule